// File: doc/BRIEF.md
# Serial Control Port with Acknowledge

This block takes a 16-bit control word from a host over a three-wire serial link and holds the decoded mode bits for the circuitry around it. The link has an enable line, a serial clock and an open-drain data line. The host raises enable, then shifts the word least significant bit first. The block samples each bit on a rising edge of the serial clock. The low seven bits carry a fixed address pattern. The upper eight bits carry the control fields.

The word is written into the control register on the 16th rising serial clock edge, but only if the address matches. On the next falling edge the block turns on its pull-down, which drives the data line low as an acknowledge. It keeps pulling until the host drops enable. A frame that ends before 16 edges leaves the register unchanged. Edges after the 16th have no effect. Two of the control bits are also decoded into a four-way operating-mode output.

The open-drain line is split into two signals: a data input from the line and an active-high pull-down enable output. The serial signals are asynchronous to the system clock. Each one passes through a two-flop synchronizer, and the serial clock edges are found by comparing successive synchronized samples.

The link carries only the host's single write and its acknowledge. It has no valid/ready handshake, so there is no back-pressure. The host must pace its serial clock slowly enough for the block to see every edge.

Top module: `serial_ctrl_port`

## Requirements
- R1: Serial bit i (i = 0 first) becomes word bit i. Word bits map to outputs as follows: bits 15:14 to test_mode[1:0], bit 13 to adj_off, bit 12 to adj_go, bit 11 to sleep_on, bit 10 to edge_pol, bit 9 to meas_sel and bit 8 to coef_sel.
- R2: After reset, every control output is 0, ack_pull is 0 and op_mode is 0.
- R3: A frame of 16 or more rising edges is committed on its 16th rising edge when bit 6 is 0 and bits 5 to 1 are all 1. Bits 7 and 0 are ignored.
- R4: A frame with 15 or fewer rising edges before enable falls leaves every control output unchanged and gives no acknowledge.
- R5: With 17 or more rising edges, the stored value is the first 16 bits, and later edges do not alter it.
- R6: ack_pull stays 0 after the 16th rising edge and goes to 1 after the falling edge that follows it.
- R7: Once asserted, ack_pull stays 1 through further clock edges until enable goes low. It is then released to 0.
- R8: A 16-bit frame whose address bits fail the pattern of R3 leaves the control outputs unchanged and is not acknowledged.
- R9: op_mode is {meas_sel, edge_pol}. 0 means falling-edge phase conversion, 1 rising-edge phase conversion, 2 negative half-period reference output, and 3 positive half-period reference output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en | input | 1 | Frame enable from host, high during a transfer |
| ser_clk | input | 1 | Serial clock from host |
| ser_dat | input | 1 | Level of the open-drain data line |
| ack_pull | output | 1 | When 1, turns on the pull-down of the data line |
| test_mode | output | 2 | Test mode field |
| adj_off | output | 1 | Auto-adjust disable |
| adj_go | output | 1 | Auto-adjust start |
| sleep_on | output | 1 | Sleep request |
| edge_pol | output | 1 | Edge / polarity select |
| meas_sel | output | 1 | Coefficient measurement mode select |
| coef_sel | output | 1 | Converter coefficient select |
| op_mode | output | 2 | Decoded operating mode |

## Verification
The bench builds the block with its defaults: a 16-bit word, a 7-bit address with mask 0x7E and value 0x3E, and two synchronizer stages. It drives a serial clock with a half period of eight system cycles, so every edge clears the synchronizer and edge detector before the next edge arrives.

With this setup the bench reaches the cases that decide a frame's fate:
- frames of 15, 16 and 20 edges;
- the window between the 16th rising edge and the falling edge after it, where the acknowledge must still be off;
- the acknowledge held across extra edges;
- addresses that fail on bit 6 or on bit 1.

// File: rtl/scp_pkg.sv
package scp_pkg;
  // Control fields in word order, most significant first.
  typedef struct packed {
    logic [1:0] test_mode;
    logic       adj_off;
    logic       adj_go;
    logic       sleep_on;
    logic       edge_pol;
    logic       meas_sel;
    logic       coef_sel;
  } ctrl_t;

  localparam int CTRL_BITS = $bits(ctrl_t);

  typedef enum logic [1:0] {
    OPM_FALL_CONV = 2'd0,
    OPM_RISE_CONV = 2'd1,
    OPM_NEG_REF   = 2'd2,
    OPM_POS_REF   = 2'd3
  } opm_e;
endpackage

// File: rtl/scp_sync.sv
module scp_sync #(
  parameter int W      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d;
  end

  for (genvar k = 1; k < STAGES; k++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[k] <= '0;
      else        stg[k] <= stg[k-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/scp_frame_rx.sv
module scp_frame_rx #(
  parameter int             WORD_BITS  = 16,
  parameter int             ADDR_BITS  = 7,
  parameter logic [ADDR_BITS-1:0] ADDR_MASK  = 7'h7E,
  parameter logic [ADDR_BITS-1:0] ADDR_VALUE = 7'h3E
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 en_s,
  input  logic                 sclk_s,
  input  logic                 sdat_s,
  output logic                 commit,
  output logic [WORD_BITS-1:0] word,
  output logic                 ack
);
  localparam int CNT_W = $clog2(WORD_BITS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_BITS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(WORD_BITS);

  logic                 sclk_q;
  logic                 rise, fall;
  logic [CNT_W-1:0]     cnt;
  logic [WORD_BITS-1:0] shreg;
  logic [WORD_BITS-1:0] next_word;
  logic                 armed;
  logic                 addr_ok;

  assign rise      = sclk_s & ~sclk_q;
  assign fall      = ~sclk_s & sclk_q;
  assign next_word = {sdat_s, shreg[WORD_BITS-1:1]};
  assign addr_ok   = ((next_word[ADDR_BITS-1:0] & ADDR_MASK) == ADDR_VALUE);
  assign commit    = en_s & rise & (cnt == LAST_IDX) & addr_ok;
  assign word      = next_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_q <= 1'b0;
    else        sclk_q <= sclk_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
      armed <= 1'b0;
      ack   <= 1'b0;
    end else if (!en_s) begin
      cnt   <= '0;
      armed <= 1'b0;
      ack   <= 1'b0;
    end else begin
      if (rise && (cnt < FULL_CNT)) begin
        shreg <= next_word;
        cnt   <= cnt + 1'b1;
      end
      if (commit)        armed <= 1'b1;
      if (fall && armed) ack   <= 1'b1;
    end
  end

  // R5
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);

  // R6
  ack_after_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !ack);

  // R6
  ack_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack) |-> ($past(sclk_q) && !$past(sclk_s)));

  // R7
  ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> !ack);
endmodule

// File: rtl/scp_ctrl_reg.sv
module scp_ctrl_reg
  import scp_pkg::*;
#(
  parameter int             WORD_BITS  = 16,
  parameter int             ADDR_BITS  = 7,
  parameter logic [ADDR_BITS-1:0] ADDR_MASK  = 7'h7E,
  parameter logic [ADDR_BITS-1:0] ADDR_VALUE = 7'h3E
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 commit,
  input  logic [WORD_BITS-1:0] word,
  output ctrl_t                ctrl,
  output opm_e                 opm
);
  localparam int FIELD_LSB = WORD_BITS - CTRL_BITS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctrl <= '0;
    else if (commit) ctrl <= ctrl_t'(word[WORD_BITS-1:FIELD_LSB]);
  end

  always_comb begin
    unique case ({ctrl.meas_sel, ctrl.edge_pol})
      2'b00:   opm = OPM_FALL_CONV;
      2'b01:   opm = OPM_RISE_CONV;
      2'b10:   opm = OPM_NEG_REF;
      default: opm = OPM_POS_REF;
    endcase
  end

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ctrl));

  // R8
  addr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> ((word[ADDR_BITS-1:0] & ADDR_MASK) == ADDR_VALUE));

  // R9
  mode_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(ctrl.meas_sel) && $stable(ctrl.edge_pol)) |-> $stable(opm));
endmodule

// File: rtl/serial_ctrl_port.sv
module serial_ctrl_port
  import scp_pkg::*;
#(
  parameter int             WORD_BITS   = 16,
  parameter int             ADDR_BITS   = 7,
  parameter logic [ADDR_BITS-1:0] ADDR_MASK   = 7'h7E,
  parameter logic [ADDR_BITS-1:0] ADDR_VALUE  = 7'h3E,
  parameter int             SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ser_en,
  input  logic       ser_clk,
  input  logic       ser_dat,
  output logic       ack_pull,
  output logic [1:0] test_mode,
  output logic       adj_off,
  output logic       adj_go,
  output logic       sleep_on,
  output logic       edge_pol,
  output logic       meas_sel,
  output logic       coef_sel,
  output logic [1:0] op_mode
);
  logic [2:0]           raw_in, sync_out;
  logic                 commit;
  logic [WORD_BITS-1:0] word;
  ctrl_t                ctrl;
  opm_e                 opm;

  assign raw_in = {ser_en, ser_clk, ser_dat};

  scp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw_in), .q(sync_out)
  );

  scp_frame_rx #(
    .WORD_BITS(WORD_BITS), .ADDR_BITS(ADDR_BITS),
    .ADDR_MASK(ADDR_MASK), .ADDR_VALUE(ADDR_VALUE)
  ) u_rx (
    .clk(clk), .rst_n(rst_n),
    .en_s(sync_out[2]), .sclk_s(sync_out[1]), .sdat_s(sync_out[0]),
    .commit(commit), .word(word), .ack(ack_pull)
  );

  scp_ctrl_reg #(
    .WORD_BITS(WORD_BITS), .ADDR_BITS(ADDR_BITS),
    .ADDR_MASK(ADDR_MASK), .ADDR_VALUE(ADDR_VALUE)
  ) u_reg (
    .clk(clk), .rst_n(rst_n), .commit(commit), .word(word),
    .ctrl(ctrl), .opm(opm)
  );

  assign test_mode = ctrl.test_mode;
  assign adj_off   = ctrl.adj_off;
  assign adj_go    = ctrl.adj_go;
  assign sleep_on  = ctrl.sleep_on;
  assign edge_pol  = ctrl.edge_pol;
  assign meas_sel  = ctrl.meas_sel;
  assign coef_sel  = ctrl.coef_sel;
  assign op_mode   = opm;
endmodule

// File: tb/serial_ctrl_port_test.sv
module serial_ctrl_port_test;
  localparam int H = 8;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_en = 1'b0, ser_clk = 1'b0, ser_dat = 1'b1;
  logic ack_pull, adj_off, adj_go, sleep_on, edge_pol, meas_sel, coef_sel;
  logic [1:0] test_mode, op_mode;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [7:0] model = 8'h00;

  always #4 clk = ~clk;

  serial_ctrl_port uut (
    .clk(clk), .rst_n(rst_n), .ser_en(ser_en), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .ack_pull(ack_pull), .test_mode(test_mode),
    .adj_off(adj_off), .adj_go(adj_go), .sleep_on(sleep_on),
    .edge_pol(edge_pol), .meas_sel(meas_sel), .coef_sel(coef_sel),
    .op_mode(op_mode)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk_fields(input string tag);
    chk({tag, " R1 fields"},
        {24'd0, test_mode, adj_off, adj_go, sleep_on, edge_pol, meas_sel, coef_sel},
        {24'd0, model});
    chk({tag, " R9 op_mode"}, {30'd0, op_mode}, {30'd0, model[1], model[2]});
  endtask

  // Sends n rising edges; bits past 16 are the inverse of the word's low bits.
  task automatic send_frame(input logic [15:0] w, input int n, input string tag);
    logic exp_ack;
    exp_ack = (n >= 16) && (w[6] == 1'b0) && (w[5:1] == 5'b11111);
    ser_en = 1'b1;
    wait_cyc(4);
    for (int i = 0; i < n; i++) begin
      ser_dat = (i < 16) ? w[i] : ~w[i-16];
      wait_cyc(H);
      ser_clk = 1'b1;
      wait_cyc(H);
      if (i == 15) chk({tag, " R6 no ack before fall"}, {31'd0, ack_pull}, 32'd0);
      ser_clk = 1'b0;
      wait_cyc(H);
      if (i == 15) chk({tag, " R6 R8 ack after fall"}, {31'd0, ack_pull}, {31'd0, exp_ack});
    end
    if (n > 16) chk({tag, " R7 ack held"}, {31'd0, ack_pull}, {31'd0, exp_ack});
    if (n < 16) chk({tag, " R4 no ack short"}, {31'd0, ack_pull}, 32'd0);
    ser_en = 1'b0;
    ser_dat = 1'b1;
    wait_cyc(6);
    chk({tag, " R7 ack released"}, {31'd0, ack_pull}, 32'd0);
    if (exp_ack) model = w[15:8];
    chk_fields(tag);
  endtask

  task automatic t_reset();
    chk("R2 ack at reset", {31'd0, ack_pull}, 32'd0);
    chk_fields("R2 reset");
  endtask

  task automatic t_full();
    send_frame({8'hA5, 1'b1, 7'h3F}, 16, "R3 full frame");
    send_frame({8'h5A, 1'b0, 7'h3E}, 16, "R3 bit0 bit7 ignored");
  endtask

  task automatic t_modes();
    for (int m = 0; m < 4; m++)
      send_frame({5'b01000, m[0], m[1], 1'b1, 1'b0, 7'h3E}, 16, "R9 mode");
  endtask

  task automatic t_short();
    send_frame({8'hFF, 1'b0, 7'h3E}, 15, "R4 short frame");
    send_frame({8'h00, 1'b0, 7'h3E}, 3, "R4 tiny frame");
  endtask

  task automatic t_long();
    send_frame({8'h3C, 1'b0, 7'h3E}, 20, "R5 long frame");
  endtask

  task automatic t_badaddr();
    send_frame({8'hFF, 1'b0, 7'h7E}, 16, "R8 bit6 set");
    send_frame({8'hFF, 1'b0, 7'h3C}, 16, "R8 bit1 clear");
  endtask

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_full();
    t_modes();
    t_short();
    t_long();
    t_badaddr();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule